// File: doc/BRIEF.md
# Temporal Isolation Level Controller

This block follows the isolation level of a staged boot. It starts at level 1 after reset and can only move up, one step per request, until it reaches level 3. While the level rises, it answers sector access queries against a protected flash area for each bank. Each bank's protected area is bounded by a start sector and an end sector, supplied on configuration inputs.

From level 2 upwards, the bank's start-to-end range is closed. At level 3, a further window is also closed. That window is a number of sectors just above the end sector, and its size is held in a volatile extension register. Software may enlarge the extension register while the level is below 3. A write that would shrink it is dropped. Once level 3 is reached, the register is frozen until reset.

Queries arrive on a valid/ready stream and answers come back one cycle later on a response strobe. The query side never applies back-pressure: `q_ready` is tied high, so every cycle with `q_valid` high is one accepted query. The response has no ready input and must be taken in the cycle it is shown. A refused query also raises a violation pulse in that same cycle.

Top module: `tiso_ctrl`

## Requirements
- R1: After reset, `level` is 1, `ext_value` is 0 and `r_valid`, `r_grant` and `r_viol` are 0.
- R2: Each clock with `lvl_inc` high raises `level` by exactly one (encoding: 2'd1, 2'd2, 2'd3). At 3 the request has no effect.
- R3: `level` never decreases except through reset.
- R4: While `level` is 1, every query is granted.
- R5: While `level` is 2 or 3, a query whose sector `s` satisfies start <= s <= end of the addressed bank is refused. The bank index is `q_bank`. Bank i's fields sit at bits [i*SECT_W +: SECT_W] of `cfg_start` and `cfg_end`.
- R6: While `level` is 3, a query with end < s <= end + `ext_value` is also refused. At level 2 those sectors are granted.
- R7: A write to the extension register is taken when its data is not below the present value and `level` is below 3. A write with lower data leaves the value unchanged.
- R8: While `level` is 3, writes to the extension register have no effect.
- R9: Each accepted query produces exactly one response, one cycle later. `r_valid` is high for that cycle only, `r_grant` is high if the query is allowed, and `r_viol` is high if it is refused. Level and extension changes made in the same cycle as the query apply only to later queries.
- R10: The ranges of one bank do not affect queries addressed to another bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_start | input | NUM_BANKS*SECT_W | Per-bank first protected sector |
| cfg_end | input | NUM_BANKS*SECT_W | Per-bank last protected sector |
| lvl_inc | input | 1 | Request to raise the level by one |
| ext_wr_en | input | 1 | Extension register write strobe |
| ext_wr_data | input | EXT_W | Extension value to write |
| ext_value | output | EXT_W | Present extension value |
| level | output | 2 | Present isolation level |
| q_valid | input | 1 | Query valid |
| q_ready | output | 1 | Query ready, always high |
| q_bank | input | BANK_W | Queried bank |
| q_sector | input | SECT_W | Queried sector |
| r_valid | output | 1 | Response strobe |
| r_grant | output | 1 | Query allowed |
| r_viol | output | 1 | Query refused |

## Verification
The assertions assume that reset is applied at the start of the run. They also assume that the configuration inputs stay constant while queries are in flight, so each answer depends only on level and extension state. The bench sets both banks' bounds once, before reset is released, and never changes them afterwards. It drives every query, write and level request on the falling edge. Each query is one cycle long, so responses never overlap.

// File: rtl/tiso_pkg.sv
package tiso_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_BOOT  = 2'd1;
  localparam lvl_t LVL_STAGE = 2'd2;
  localparam lvl_t LVL_FINAL = 2'd3;
endpackage

// File: rtl/tiso_level_ctr.sv
module tiso_level_ctr
  import tiso_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  output lvl_t level
);
  lvl_t level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      level_q <= LVL_BOOT;
    else if (inc && level_q != LVL_FINAL)
      level_q <= level_q + 2'd1;
  end

  assign level = level_q;

  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    level_q != 2'd0); // R2
  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, level_q} <= {1'b0, $past(level_q)} + 3'd1); // R2
  AST_LEVEL_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    level_q >= $past(level_q)); // R3
endmodule

// File: rtl/tiso_ext_reg.sv
module tiso_ext_reg
  import tiso_pkg::*;
#(
  parameter int EXT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lvl_t             level,
  input  logic             wr_en,
  input  logic [EXT_W-1:0] wr_data,
  output logic [EXT_W-1:0] ext
);
  logic [EXT_W-1:0] ext_q;
  logic             take;

  assign take = wr_en && (level != LVL_FINAL) && (wr_data >= ext_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ext_q <= '0;
    else if (take)
      ext_q <= wr_data;
  end

  assign ext = ext_q;

  AST_EXT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    ext_q >= $past(ext_q)); // R7
  AST_EXT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(level) == LVL_FINAL |-> $stable(ext_q)); // R8
endmodule

// File: rtl/tiso_bank_guard.sv
module tiso_bank_guard
  import tiso_pkg::*;
#(
  parameter int SECT_W = 7,
  parameter int EXT_W  = 7
) (
  input  lvl_t              level,
  input  logic [SECT_W-1:0] lo,
  input  logic [SECT_W-1:0] hi,
  input  logic [EXT_W-1:0]  ext,
  input  logic [SECT_W-1:0] sector,
  output logic              deny
);
  localparam int SUM_W = ((SECT_W > EXT_W) ? SECT_W : EXT_W) + 1;

  logic [SUM_W-1:0] sec_w, hi_w, ext_top;
  logic             in_base, in_ext;

  always_comb begin
    sec_w   = SUM_W'(sector);
    hi_w    = SUM_W'(hi);
    ext_top = hi_w + SUM_W'(ext);
    in_base = (sector >= lo) && (sector <= hi);
    in_ext  = (sec_w > hi_w) && (sec_w <= ext_top);
    deny    = ((level != LVL_BOOT) && in_base) ||
              ((level == LVL_FINAL) && in_ext);
  end
endmodule

// File: rtl/tiso_ctrl.sv
module tiso_ctrl
  import tiso_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int SECT_W    = 7,
  parameter int EXT_W     = 7,
  parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*SECT_W-1:0] cfg_start,
  input  logic [NUM_BANKS*SECT_W-1:0] cfg_end,
  input  logic                        lvl_inc,
  input  logic                        ext_wr_en,
  input  logic [EXT_W-1:0]            ext_wr_data,
  output logic [EXT_W-1:0]            ext_value,
  output logic [1:0]                  level,
  input  logic                        q_valid,
  output logic                        q_ready,
  input  logic [BANK_W-1:0]           q_bank,
  input  logic [SECT_W-1:0]           q_sector,
  output logic                        r_valid,
  output logic                        r_grant,
  output logic                        r_viol
);
  localparam int BANK_SPAN = 1 << BANK_W;

  lvl_t                 lvl;
  logic [EXT_W-1:0]     ext;
  logic [BANK_SPAN-1:0] deny_pad;
  logic                 deny_sel;

  tiso_level_ctr u_level (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (lvl_inc),
    .level (lvl)
  );

  tiso_ext_reg #(.EXT_W(EXT_W)) u_ext (
    .clk     (clk),
    .rst_n   (rst_n),
    .level   (lvl),
    .wr_en   (ext_wr_en),
    .wr_data (ext_wr_data),
    .ext     (ext)
  );

  for (genvar b = 0; b < BANK_SPAN; b++) begin : g_bank
    if (b < NUM_BANKS) begin : g_real
      tiso_bank_guard #(.SECT_W(SECT_W), .EXT_W(EXT_W)) u_guard (
        .level  (lvl),
        .lo     (cfg_start[b*SECT_W +: SECT_W]),
        .hi     (cfg_end[b*SECT_W +: SECT_W]),
        .ext    (ext),
        .sector (q_sector),
        .deny   (deny_pad[b])
      );
    end else begin : g_none
      assign deny_pad[b] = 1'b0;
    end
  end

  assign deny_sel = deny_pad[q_bank];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_valid <= 1'b0;
      r_grant <= 1'b0;
      r_viol  <= 1'b0;
    end else begin
      r_valid <= q_valid;
      r_grant <= q_valid && !deny_sel;
      r_viol  <= q_valid && deny_sel;
    end
  end

  assign q_ready   = 1'b1;
  assign level     = lvl;
  assign ext_value = ext;

  AST_VIOL_ONLY_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    r_viol |-> r_valid && !r_grant); // R9
  AST_RESP_FROM_QUERY: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid |-> $past(q_valid)); // R9
  AST_BOOT_ALL_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid && $past(lvl) == LVL_BOOT |-> r_grant); // R4
endmodule

// File: tb/tiso_ctrl_test.sv
module tiso_ctrl_test;
  localparam int NB = 2, SW = 7, EW = 7, BW = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NB*SW-1:0] cfg_start, cfg_end;
  logic          lvl_inc = 1'b0, ext_wr_en = 1'b0;
  logic [EW-1:0] ext_wr_data = '0;
  logic [EW-1:0] ext_value;
  logic [1:0]    level;
  logic          q_valid = 1'b0, q_ready;
  logic [BW-1:0] q_bank = '0;
  logic [SW-1:0] q_sector = '0;
  logic          r_valid, r_grant, r_viol;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tiso_ctrl #(.NUM_BANKS(NB), .SECT_W(SW), .EXT_W(EW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_end(cfg_end),
    .lvl_inc(lvl_inc), .ext_wr_en(ext_wr_en), .ext_wr_data(ext_wr_data),
    .ext_value(ext_value), .level(level), .q_valid(q_valid), .q_ready(q_ready),
    .q_bank(q_bank), .q_sector(q_sector), .r_valid(r_valid), .r_grant(r_grant),
    .r_viol(r_viol)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bump();
    @(negedge clk); lvl_inc = 1'b1;
    @(negedge clk); lvl_inc = 1'b0;
  endtask

  task automatic wr_ext(int v);
    @(negedge clk); ext_wr_en = 1'b1; ext_wr_data = EW'(v);
    @(negedge clk); ext_wr_en = 1'b0;
  endtask

  task automatic ask(string req, int bank, int sec, bit exp_grant);
    @(negedge clk);
    q_valid = 1'b1; q_bank = BW'(bank); q_sector = SW'(sec);
    @(negedge clk);
    q_valid = 1'b0;
    check({req, " r_valid"}, r_valid, 1);
    check({req, " r_grant"}, r_grant, exp_grant);
    check({req, " r_viol"}, r_viol, !exp_grant);
    @(negedge clk);
    check("R9 strobe single cycle", r_valid + r_viol, 0);
  endtask

  task automatic t_reset();
    check("R1 level", level, 1);
    check("R1 ext", ext_value, 0);
    check("R1 r_valid", r_valid, 0);
    check("R1 r_viol", r_viol, 0);
    check("R9 q_ready", q_ready, 1);
  endtask

  task automatic t_boot_level();
    ask("R4 bank0 inside", 0, 15, 1);
    ask("R4 bank1 inside", 1, 45, 1);
  endtask

  task automatic t_ext_writes();
    wr_ext(5);  check("R7 grow", ext_value, 5);
    wr_ext(3);  check("R7 shrink dropped", ext_value, 5);
    wr_ext(8);  check("R7 grow again", ext_value, 8);
  endtask

  task automatic t_stage_level();
    bump(); check("R2 step to 2", level, 2);
    ask("R5 bank0 start", 0, 10, 0);
    ask("R5 bank0 end", 0, 20, 0);
    ask("R5 bank0 below", 0, 9, 1);
    ask("R6 ext window open at 2", 0, 21, 1);
    ask("R5 bank1 start", 1, 40, 0);
    ask("R10 bank1 ignores bank0 range", 1, 15, 1);
    ask("R10 bank0 ignores bank1 range", 0, 45, 1);
  endtask

  task automatic t_final_level();
    bump(); check("R2 step to 3", level, 3);
    ask("R6 bank0 end+1", 0, 21, 0);
    ask("R6 bank0 end+ext", 0, 28, 0);
    ask("R6 bank0 past window", 0, 29, 1);
    ask("R6 bank1 end+ext", 1, 57, 0);
    ask("R6 bank1 past window", 1, 58, 1);
    ask("R5 still closed at 3", 1, 49, 0);
    wr_ext(20); check("R8 write frozen", ext_value, 8);
    ask("R8 window unchanged", 0, 29, 1);
    bump(); check("R2 saturate", level, 3);
    check("R3 no drop", level, 3);
  endtask

  task automatic t_rereset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1 level after reset", level, 1);
    check("R1 ext after reset", ext_value, 0);
    ask("R4 open after reset", 0, 12, 1);
  endtask

  initial begin
    cfg_start = {SW'(40), SW'(10)};
    cfg_end   = {SW'(49), SW'(20)};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_boot_level();
    t_ext_writes();
    t_stage_level();
    t_final_level();
    t_rereset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule